// File: doc/BRIEF.md
# Re-reference Replacement Victim Selector

This block holds the replacement state of one set of an N-way set-associative cache and names the way to evict. Each way carries a small re-reference value: the highest value marks a line expected to be reused furthest in the future, and zero marks a line that was just reused. The cache controller reports hits as touch events and line installs as fill events, each with a way number. It raises a victim request when it needs a slot.

A policy parameter picks one of two behaviours. In not-recently-used mode every way holds one bit. In counter mode every way holds a multi-bit counter, 3 bits by default. In counter mode a fill installs the line at a distant value, 6 by default, so a line that is never reused leaves the set soon. A victim request ages the set when needed and returns the chosen way one cycle later. Tag storage, set indexing and adaptive choice between insertion policies belong to the surrounding cache.

Top module: `rrsel_top`

## Requirements
- R1: After synchronous active-low reset every way holds the maximum value (7 for 3-bit counters, 1 in bit mode), and `victim_vld` is 0.
- R2: A touch event sets that way's value to 0.
- R3: A fill event sets that way's value to the insertion value. This is 6 by default in counter mode and 0 in bit mode.
- R4: The victim is the lowest-numbered way that holds the maximum value.
- R5: If no way holds the maximum value at a request, all ways are raised by the same amount in that cycle until the largest reaches the maximum. In bit mode this sets all bits back to one. The victim is then the lowest-numbered way that was largest.
- R6: `victim_vld` is high exactly in the cycle after a request, and only then. `victim_way` reflects the state before that cycle's touch and fill events. Those events then override the aged value of their own way.
- R7: When a touch and a fill name the same way in the same cycle, the touch wins and the way becomes 0.
- R8: With the bit-mode policy selected, each way keeps a single bit, and R1 to R7 hold with maximum 1 and insertion value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| touch_en | input | 1 | Hit event strobe |
| touch_way | input | $clog2(WAYS) | Way that was hit |
| fill_en | input | 1 | Fill event strobe |
| fill_way | input | $clog2(WAYS) | Way that was filled |
| vreq | input | 1 | Victim request |
| victim_way | output | $clog2(WAYS) | Chosen way, valid with victim_vld |
| victim_vld | output | 1 | Victim result strobe |

## Verification
Touch and fill events change state at the next clock edge. Their effect can only be seen through a later victim choice. A victim result appears exactly one edge after its request.

The bench drives each stimulus after a falling edge. It waits one rising edge and samples the outputs at the following falling edge. There it compares them with a bench model that advanced one step for the same inputs.

A counter-mode instance and a bit-mode instance receive identical stimulus, so both policies are compared every cycle.

// File: rtl/rrsel_pkg.sv
// Shared definitions for the replacement victim selector.
// Assumes nothing beyond IEEE 1800-2017 packages.
package rrsel_pkg;

    // Replacement flavour chosen at elaboration time
    typedef enum logic {
        POL_BIT   = 1'b0,
        POL_COUNT = 1'b1
    } policy_e;

endpackage

// File: rtl/rrsel_way_cell.sv
// One way's re-reference value.
// On a request it adds the aging amount. A fill overrides that with the
// insertion value, and a touch overrides everything with zero.
// Assumes age_add never pushes the value past its maximum.
module rrsel_way_cell #(
    parameter int VW      = 3,
    parameter int INS_VAL = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          age_en,
    input  logic [VW-1:0] age_add,
    input  logic          hit_en,
    input  logic          fill_en,
    output logic [VW-1:0] val_q
);
    localparam logic [VW-1:0] MAXV  = '1;
    localparam logic [VW-1:0] INS_V = INS_VAL[VW-1:0];

    logic [VW-1:0] val_d;

    // Next value: aging, then fill, then touch (highest priority)
    always_comb begin
        val_d = val_q;
        if (age_en)  val_d = val_q + age_add;
        if (fill_en) val_d = INS_V;
        if (hit_en)  val_d = '0;
    end

    // State register, reset to the eviction end
    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= MAXV;
        else        val_q <= val_d;
    end

    assert_touch_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_en |=> (val_q == '0));

    assert_fill_insert_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !hit_en) |=> (val_q == INS_V));

endmodule

// File: rtl/rrsel_pick.sv
// Finds the largest value across the ways and the lowest way that holds it.
// Purely combinational; ties resolve towards way 0.
module rrsel_pick #(
    parameter int WAYS = 8,
    parameter int VW   = 3,
    parameter int IW   = $clog2(WAYS)
) (
    input  logic [VW-1:0] vals [WAYS],
    output logic [VW-1:0] top_val,
    output logic [IW-1:0] sel_idx
);
    // Largest value in the set
    always_comb begin
        top_val = '0;
        for (int w = 0; w < WAYS; w++)
            if (vals[w] > top_val) top_val = vals[w];
    end

    // Lowest-numbered way equal to the largest value
    always_comb begin
        sel_idx = '0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (vals[w] == top_val) sel_idx = IW'(w);
    end

endmodule

// File: rtl/rrsel_top.sv
// Per-set replacement selector with a bit-mode or counter-mode policy.
// A victim request ages every way so that the largest value reaches the
// maximum, and registers the chosen way. Touch and fill events in the
// same cycle override their own way after the aging step.
// Assumes touch_way and fill_way are below WAYS.
module rrsel_top
    import rrsel_pkg::*;
#(
    parameter int      WAYS     = 8,
    parameter policy_e POLICY   = POL_COUNT,
    parameter int      CNT_W    = 3,
    parameter int      INS_DIST = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    touch_en,
    input  logic [$clog2(WAYS)-1:0] touch_way,
    input  logic                    fill_en,
    input  logic [$clog2(WAYS)-1:0] fill_way,
    input  logic                    vreq,
    output logic [$clog2(WAYS)-1:0] victim_way,
    output logic                    victim_vld
);
    localparam int IW      = $clog2(WAYS);
    localparam int VW      = (POLICY == POL_BIT) ? 1 : CNT_W;
    localparam int INS_VAL = (POLICY == POL_BIT) ? 0 : INS_DIST;
    localparam logic [VW-1:0] MAXV = '1;

    logic [VW-1:0] way_val [WAYS];
    logic [VW-1:0] top_val;
    logic [IW-1:0] sel_idx;
    logic [VW-1:0] age_add;

    // Amount that lifts the largest value to the maximum
    always_comb age_add = MAXV - top_val;

    rrsel_pick #(.WAYS(WAYS), .VW(VW), .IW(IW)) u_pick (
        .vals    (way_val),
        .top_val (top_val),
        .sel_idx (sel_idx)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        rrsel_way_cell #(.VW(VW), .INS_VAL(INS_VAL)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .age_en  (vreq),
            .age_add (age_add),
            .hit_en  (touch_en && (touch_way == IW'(w))),
            .fill_en (fill_en && (fill_way == IW'(w))),
            .val_q   (way_val[w])
        );
    end

    // Result register, one cycle behind the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim_vld <= 1'b0;
            victim_way <= '0;
        end else begin
            victim_vld <= vreq;
            if (vreq) victim_way <= sel_idx;
        end
    end

    assert_vld_after_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vreq |=> victim_vld);

    assert_no_vld_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !vreq |=> !victim_vld);

    assert_victim_at_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vreq && !touch_en && !fill_en) |=> (way_val[victim_way] == MAXV));

    assert_touch_beats_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_en && fill_en && (touch_way == fill_way)) |=> (way_val[$past(touch_way)] == '0));

endmodule

// File: tb/rrsel_top_tb.sv
// Bench: a counter-mode and a bit-mode selector get identical stimulus.
// Each is compared every cycle against a bench model.
module rrsel_top_tb;
    import rrsel_pkg::*;

    localparam int WAYS = 8;
    localparam int IW   = $clog2(WAYS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          touch_en = 1'b0, fill_en = 1'b0, vreq = 1'b0;
    logic [IW-1:0] touch_way = '0, fill_way = '0;
    logic [IW-1:0] vw_c, vw_b;
    logic          vv_c, vv_b;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // model[0] = counter mode, model[1] = bit mode
    int model [2][WAYS];
    int maxv  [2] = '{7, 1};
    int insv  [2] = '{6, 0};
    int exp_way [2];
    bit exp_vld;

    always #2 clk = ~clk;   // 250 MHz

    rrsel_top #(.WAYS(WAYS), .POLICY(POL_COUNT)) u_dut (
        .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_way(touch_way),
        .fill_en(fill_en), .fill_way(fill_way), .vreq(vreq),
        .victim_way(vw_c), .victim_vld(vv_c));

    rrsel_top #(.WAYS(WAYS), .POLICY(POL_BIT)) u_dut_bit (
        .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_way(touch_way),
        .fill_en(fill_en), .fill_way(fill_way), .vreq(vreq),
        .victim_way(vw_b), .victim_vld(vv_b));

    function automatic void model_reset();
        for (int m = 0; m < 2; m++)
            for (int w = 0; w < WAYS; w++) model[m][w] = maxv[m];
    endfunction

    // One clock of the model: choose and age, then fill, then touch
    function automatic void model_step(bit t, int tw, bit f, int fw, bit r);
        exp_vld = r;
        for (int m = 0; m < 2; m++) begin
            if (r) begin
                int top = 0;
                int idx = -1;
                for (int w = 0; w < WAYS; w++) if (model[m][w] > top) top = model[m][w];
                for (int w = 0; w < WAYS; w++) if (idx < 0 && model[m][w] == top) idx = w;
                exp_way[m] = idx;
                for (int w = 0; w < WAYS; w++) model[m][w] += maxv[m] - top;
            end
            if (f) model[m][fw] = insv[m];
            if (t) model[m][tw] = 0;
        end
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one cycle of stimulus and check the outputs one edge later
    task automatic cyc(bit t, int tw, bit f, int fw, bit r, string tag);
        touch_en = t; touch_way = IW'(tw);
        fill_en = f;  fill_way = IW'(fw);
        vreq = r;
        model_step(t, tw, f, fw, r);
        @(posedge clk);
        @(negedge clk);
        check({tag, " R6 vld"}, int'(vv_c), int'(exp_vld));
        check({tag, " R8 R6 vld"}, int'(vv_b), int'(exp_vld));
        if (exp_vld) begin
            check({tag, " R4 way"}, int'(vw_c), exp_way[0]);
            check({tag, " R8 way"}, int'(vw_b), exp_way[1]);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 vld after reset", int'(vv_c), 0);
        check("R1 R8 vld after reset", int'(vv_b), 0);

        // R1: fresh set, every way at maximum, lowest picked repeatedly
        cyc(0, 0, 0, 0, 1, "R1 first pick");
        cyc(0, 0, 0, 0, 1, "R1 repeat pick");
        // R2: touching way 0 moves the choice to way 1
        cyc(1, 0, 0, 0, 0, "R2 touch0");
        cyc(0, 0, 0, 0, 1, "R2 pick after touch");
        // R3: fill every way, then request forces aging (R5)
        for (int w = 0; w < WAYS; w++) cyc(0, 0, 1, w, 0, "R3 fill");
        cyc(0, 0, 0, 0, 1, "R3 R5 pick after fills");
        // R5: touch all ways so nothing is at maximum, then request
        for (int w = 0; w < WAYS; w++) cyc(1, w, 0, 0, 0, "R5 touch all");
        cyc(1, 3, 0, 0, 1, "R5 R6 aging with touch");
        cyc(0, 0, 0, 0, 1, "R5 pick after aging");
        // R7: touch and fill to the same way, same cycle
        cyc(1, 0, 1, 0, 0, "R7 same way");
        cyc(0, 0, 1, 5, 1, "R7 R6 pick with fill");
        cyc(0, 0, 0, 0, 0, "R6 idle");

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            bit t = ($urandom % 3) == 0;
            bit f = ($urandom % 4) == 0;
            bit r = ($urandom % 3) == 0;
            int tw = int'($urandom % WAYS);
            int fw = ($urandom % 5 == 0) ? tw : int'($urandom % WAYS);
            cyc(t, tw, f, fw, r, "R4 R5 random");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule